// File: doc/BRIEF.md
# Serial Bus Frame Header Receiver

This block sits behind the bit decoder of a half-duplex, multi-master serial bus. It takes the already recovered bit stream as a one-cycle valid strobe with a bit value, plus a separate strobe that marks a detected start bit. From that stream it parses the header of each frame: the broadcast flag, the sender's 12-bit address, the 12-bit target address, a 4-bit control code and an 8-bit length. Each field carries its own even parity bit.

A unit address holds a 4-bit group number in its upper bits and an 8-bit unit number in its lower bits. For individually addressed frames the block answers each acknowledge slot that follows the target, control and length fields. It drives ACK when the frame is addressed to it and the field arrived intact, and NAK when a parity check fails. Broadcast frames are accepted either for everyone or for the local group, and their acknowledge slots are left released. A frame-accepted pulse marks a complete, valid header. A parity-error pulse marks an abandoned frame.

Top module: `mmbus_hdr_rx`

## Requirements
- R1: While reset is asserted and on the cycle after its release, ack_drv_o, frame_ok_o, par_err_o and bcast_o are 0 and all parsed field outputs are 0.
- R2: After a start strobe, the frame is parsed in this order: broadcast bit, 12-bit master address, 12-bit slave address, 4-bit control and 8-bit length, each sent MSB first. Each field is followed by one even-parity bit. Every field except the master address is then followed by one acknowledge slot. A broadcast bit of 0 marks a broadcast frame (bcast_o = 1); a broadcast bit of 1 marks an individual frame (bcast_o = 0).
- R3: A parity failure on the master address pulses par_err_o for one cycle and abandons the frame. No acknowledge slot is driven and frame_ok_o stays 0.
- R4: In an individual frame whose 12-bit slave address equals the local address, each of the three acknowledge slots has ack_drv_o = 1 with ack_bit_o = 0 (ACK).
- R5: In an individual frame whose slave address differs from the local address, no acknowledge slot is driven, frame_ok_o stays 0, and the rest of the frame is ignored.
- R6: A broadcast frame is accepted when the slave address is 0xFFF (all units), or when its upper 4 bits equal the local group and its lower 8 bits are all ones (group). Any other broadcast slave address is rejected. Acknowledge slots of broadcast frames are never driven.
- R7: In an individual frame, a parity failure on the slave address, control or length field pulses par_err_o and drives ack_bit_o = 1 (NAK) with ack_drv_o = 1 in the following slot. The frame is then abandoned.
- R8: After the length field's acknowledge slot of an accepted frame, frame_ok_o is high for exactly one cycle, and the parsed fields hold the received values.
- R9: A start strobe at any point abandons the frame in progress and restarts parsing at the broadcast bit.
- R10: The local address is sampled on the first clock after reset release. Later changes of local_addr_i have no effect on matching until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| local_addr_i | input | 12 | Local unit address (group in bits 11:8) |
| start_i | input | 1 | Start bit detected strobe |
| bit_vld_i | input | 1 | Decoded bit valid strobe |
| bit_i | input | 1 | Decoded bit value |
| ack_drv_o | output | 1 | Drive the current acknowledge slot |
| ack_bit_o | output | 1 | Slot value when driven: 0 ACK, 1 NAK |
| bcast_o | output | 1 | Current frame is a broadcast |
| mst_addr_o | output | 12 | Parsed master address |
| slv_addr_o | output | 12 | Parsed slave address |
| ctrl_o | output | 4 | Parsed control code |
| len_o | output | 8 | Parsed length |
| frame_ok_o | output | 1 | One-cycle pulse: header accepted |
| par_err_o | output | 1 | One-cycle pulse: parity failure |

## Verification
Frames are sent with an exact individual address match and with a mismatch that differs only in the lowest bit. The first shows ACK in every slot; the second shows silence and no acceptance. Broadcast frames are sent to all units, to the local group and to a foreign group, which separates the two accepted broadcast forms from a near miss. Single corrupted parity bits in the master-address, slave-address and control fields separate silent abandonment from a driven NAK. An interrupted frame followed by a new start, and a change of the address input after reset, show that restart and address sampling behave as specified.

// File: rtl/mmbus_pkg.sv
package mmbus_pkg;
  typedef enum logic [2:0] {S_IDLE, S_BC, S_DATA, S_PAR, S_ACK} st_e;
  typedef enum logic [1:0] {F_MA, F_SA, F_CT, F_LN} fld_e;
endpackage

// File: rtl/mmbus_field_sr.sv
module mmbus_field_sr #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] val_o,
  output logic         par_o
);
  logic [W-1:0] sr_q;
  logic         par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      par_q <= 1'b0;
    end else if (clr_i) begin
      sr_q  <= '0;
      par_q <= 1'b0;
    end else if (en_i) begin
      sr_q  <= {sr_q[W-2:0], bit_i};
      par_q <= par_q ^ bit_i;
    end
  end

  assign val_o = sr_q;
  assign par_o = par_q;
endmodule

// File: rtl/mmbus_addr_match.sv
module mmbus_addr_match #(
  parameter int ADDR_W = 12,
  parameter int UNIT_W = 8
) (
  input  logic [ADDR_W-1:0] loc_i,
  input  logic [ADDR_W-1:0] slv_i,
  input  logic              indiv_i,
  output logic              hit_o
);
  logic all_ones, grp_hit;

  assign all_ones = &slv_i;
  assign grp_hit  = (slv_i[ADDR_W-1:UNIT_W] == loc_i[ADDR_W-1:UNIT_W]) && (&slv_i[UNIT_W-1:0]);
  assign hit_o    = indiv_i ? (slv_i == loc_i) : (all_ones || grp_hit);
endmodule

// File: rtl/mmbus_hdr_rx.sv
module mmbus_hdr_rx
  import mmbus_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int UNIT_W = 8,
  parameter int CTRL_W = 4,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] local_addr_i,
  input  logic              start_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  output logic              ack_drv_o,
  output logic              ack_bit_o,
  output logic              bcast_o,
  output logic [ADDR_W-1:0] mst_addr_o,
  output logic [ADDR_W-1:0] slv_addr_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              frame_ok_o,
  output logic              par_err_o
);
  localparam int CNT_W = $clog2(ADDR_W);

  st_e               state_q;
  fld_e              fld_q;
  logic [CNT_W-1:0]  cnt_q, fld_last;
  logic [ADDR_W-1:0] loc_q, mst_q, slv_q, sr_val;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LEN_W-1:0]  len_q;
  logic              armed_q, bcast_q, drive_q, nak_q, go_q;
  logic              ok_q, err_q;
  logic              sr_par, sr_clr, sr_en, par_ok, hit, go_n, drv_n;

  // sample local address once after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      loc_q   <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      loc_q   <= local_addr_i;
    end
  end

  assign sr_en  = bit_vld_i && !start_i && (state_q == S_DATA);
  assign sr_clr = start_i || (bit_vld_i && (state_q inside {S_BC, S_PAR, S_ACK}));

  mmbus_field_sr #(.W(ADDR_W)) u_sr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sr_clr),
    .en_i  (sr_en),
    .bit_i (bit_i),
    .val_o (sr_val),
    .par_o (sr_par)
  );

  mmbus_addr_match #(.ADDR_W(ADDR_W), .UNIT_W(UNIT_W)) u_match (
    .loc_i  (loc_q),
    .slv_i  (sr_val),
    .indiv_i(!bcast_q),
    .hit_o  (hit)
  );

  always_comb begin
    case (fld_q)
      F_CT:    fld_last = CNT_W'(CTRL_W - 1);
      F_LN:    fld_last = CNT_W'(LEN_W - 1);
      default: fld_last = CNT_W'(ADDR_W - 1);
    endcase
  end

  assign par_ok = !(sr_par ^ bit_i);
  assign go_n   = par_ok && ((fld_q != F_SA) || hit);
  assign drv_n  = !bcast_q && (!par_ok || (fld_q != F_SA) || hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      fld_q   <= F_MA;
      cnt_q   <= '0;
      bcast_q <= 1'b0;
      drive_q <= 1'b0;
      nak_q   <= 1'b0;
      go_q    <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      mst_q   <= '0;
      slv_q   <= '0;
      ctrl_q  <= '0;
      len_q   <= '0;
    end else begin
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      if (start_i) begin
        state_q <= S_BC;
      end else if (bit_vld_i) begin
        case (state_q)
          S_BC: begin
            bcast_q <= !bit_i;
            fld_q   <= F_MA;
            cnt_q   <= '0;
            state_q <= S_DATA;
          end
          S_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == fld_last) state_q <= S_PAR;
          end
          S_PAR: begin
            cnt_q <= '0;
            err_q <= !par_ok;
            if (fld_q == F_MA) begin
              if (par_ok) begin
                mst_q   <= sr_val;
                fld_q   <= F_SA;
                state_q <= S_DATA;
              end else begin
                state_q <= S_IDLE;
              end
            end else begin
              if (par_ok) begin
                case (fld_q)
                  F_SA:    slv_q  <= sr_val;
                  F_CT:    ctrl_q <= sr_val[CTRL_W-1:0];
                  default: len_q  <= sr_val[LEN_W-1:0];
                endcase
              end
              drive_q <= drv_n;
              nak_q   <= !par_ok;
              go_q    <= go_n;
              state_q <= (drv_n || go_n) ? S_ACK : S_IDLE;
            end
          end
          S_ACK: begin
            if (!go_q) begin
              state_q <= S_IDLE;
            end else if (fld_q == F_LN) begin
              ok_q    <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              fld_q   <= fld_e'(fld_q + 2'd1);
              state_q <= S_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ack_drv_o  = (state_q == S_ACK) && drive_q;
  assign ack_bit_o  = nak_q;
  assign bcast_o    = bcast_q;
  assign mst_addr_o = mst_q;
  assign slv_addr_o = slv_q;
  assign ctrl_o     = ctrl_q;
  assign len_o      = len_q;
  assign frame_ok_o = ok_q;
  assign par_err_o  = err_q;

  AST_NO_DRV_BCAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_drv_o |-> !bcast_o); // R6
  AST_OK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok_o |=> !frame_ok_o); // R8
  AST_OK_NOT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_ok_o && par_err_o)); // R8
  AST_NAK_HAS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ack_drv_o) && ack_bit_o) |-> par_err_o); // R7
  AST_LOC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(armed_q)) |-> $stable(loc_q)); // R10
endmodule

// File: tb/mmbus_hdr_rx_test.sv
`timescale 1ns/1ps
module mmbus_hdr_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] local_addr = 12'h3A5;
  logic        start = 1'b0, vld = 1'b0, b = 1'b0;
  logic        ack_drv, ack_bit, bcast, frame_ok, par_err;
  logic [11:0] mst, slv;
  logic [3:0]  ctrl;
  logic [7:0]  len;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  mmbus_hdr_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .local_addr_i(local_addr),
    .start_i(start), .bit_vld_i(vld), .bit_i(b),
    .ack_drv_o(ack_drv), .ack_bit_o(ack_bit), .bcast_o(bcast),
    .mst_addr_o(mst), .slv_addr_o(slv), .ctrl_o(ctrl), .len_o(len),
    .frame_ok_o(frame_ok), .par_err_o(par_err)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    @(negedge clk); vld = 1'b1; b = v;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic start_frame(input logic indiv);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    send_bit(indiv);
  endtask

  task automatic send_field(input logic [11:0] v, input int w, input logic bad);
    logic p = 1'b0;
    for (int i = w - 1; i >= 0; i--) begin
      send_bit(v[i]);
      p ^= v[i];
    end
    send_bit(p ^ bad);
  endtask

  task automatic slot(input logic drv, input logic nak, input string tag);
    chk(ack_drv, drv, {tag, " slot drive"});
    if (drv) chk(ack_bit, nak, {tag, " slot value"});
    send_bit(drv ? nak : 1'b0);
  endtask

  task automatic t_reset;
    chk({ack_drv, frame_ok, par_err, bcast}, 4'h0, "R1 flags");
    chk({mst, slv, ctrl, len}, 36'h0, "R1 fields");
  endtask

  task automatic t_indiv_hit;
    start_frame(1'b1);
    chk(bcast, 1'b0, "R2 individual flag");
    send_field(12'h123, 12, 1'b0); send_field(12'h3A5, 12, 1'b0);
    slot(1'b1, 1'b0, "R4 sa");
    send_field(12'hB, 4, 1'b0);    slot(1'b1, 1'b0, "R4 ct");
    send_field(12'h05, 8, 1'b0);   slot(1'b1, 1'b0, "R4 ln");
    chk(frame_ok, 1'b1, "R8 accept pulse");
    chk({mst, slv, ctrl, len}, {12'h123, 12'h3A5, 4'hB, 8'h05}, "R2 fields MSB first");
    @(negedge clk);
    chk(frame_ok, 1'b0, "R8 pulse one cycle");
  endtask

  task automatic t_indiv_miss;
    start_frame(1'b1);
    send_field(12'h456, 12, 1'b0); send_field(12'h3A4, 12, 1'b0);
    slot(1'b0, 1'b0, "R5 sa");
    send_field(12'h3, 4, 1'b0);    slot(1'b0, 1'b0, "R5 ct");
    send_field(12'h10, 8, 1'b0);   slot(1'b0, 1'b0, "R5 ln");
    chk(frame_ok, 1'b0, "R5 no accept");
  endtask

  task automatic t_bcast(input logic [11:0] sa, input logic acc, input string tag);
    start_frame(1'b0);
    chk(bcast, 1'b1, {tag, " R2 broadcast flag"});
    send_field(12'h777, 12, 1'b0); send_field(sa, 12, 1'b0);
    slot(1'b0, 1'b0, tag);
    send_field(12'hF, 4, 1'b0);    slot(1'b0, 1'b0, tag);
    send_field(12'hA5, 8, 1'b0);   slot(1'b0, 1'b0, tag);
    chk(frame_ok, acc, {tag, " accept"});
  endtask

  task automatic t_ma_err;
    start_frame(1'b1);
    send_field(12'h123, 12, 1'b1);
    chk(par_err, 1'b1, "R3 error pulse");
    send_field(12'h3A5, 12, 1'b0);
    slot(1'b0, 1'b0, "R3 no slot");
    chk(frame_ok, 1'b0, "R3 abandoned");
  endtask

  task automatic t_nak(input int which, input string tag);
    start_frame(1'b1);
    send_field(12'h123, 12, 1'b0);
    send_field(12'h3A5, 12, which == 0);
    if (which == 0) begin
      chk(par_err, 1'b1, {tag, " error pulse"});
      slot(1'b1, 1'b1, tag);
    end else begin
      slot(1'b1, 1'b0, tag);
      send_field(12'h3, 4, 1'b1);
      chk(par_err, 1'b1, {tag, " error pulse"});
      slot(1'b1, 1'b1, tag);
    end
    send_field(12'h3, 4, 1'b0);
    slot(1'b0, 1'b0, {tag, " abandoned"});
  endtask

  task automatic t_restart;
    start_frame(1'b1);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    start_frame(1'b1);
    send_field(12'h0F0, 12, 1'b0); send_field(12'h3A5, 12, 1'b0);
    slot(1'b1, 1'b0, "R9 sa");
    send_field(12'h1, 4, 1'b0);    slot(1'b1, 1'b0, "R9 ct");
    send_field(12'h80, 8, 1'b0);   slot(1'b1, 1'b0, "R9 ln");
    chk(frame_ok, 1'b1, "R9 accept after restart");
    chk(mst, 12'h0F0, "R9 master addr");
  endtask

  task automatic t_latch;
    local_addr = 12'h111;
    start_frame(1'b1);
    send_field(12'h222, 12, 1'b0); send_field(12'h111, 12, 1'b0);
    slot(1'b0, 1'b0, "R10 new addr ignored");
    start_frame(1'b1);
    send_field(12'h222, 12, 1'b0); send_field(12'h3A5, 12, 1'b0);
    slot(1'b1, 1'b0, "R10 old addr kept");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_indiv_hit();
    t_indiv_miss();
    t_bcast(12'hFFF, 1'b1, "R6 general");
    t_bcast(12'h3FF, 1'b1, "R6 group");
    t_bcast(12'h2FF, 1'b0, "R6 other group");
    t_bcast(12'h3FE, 1'b0, "R6 group low bits");
    t_ma_err();
    t_nak(0, "R7 sa");
    t_nak(1, "R7 ct");
    t_restart();
    t_latch();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule